// File: doc/BRIEF.md
# Console Character I/O Controller

This block connects a 16-bit processor bus to a keyboard source and a display sink through four fixed word addresses. Each device has a status word and a data word. Software polls the status words, or enables interrupts through them. It reads a captured keystroke from the keyboard data word and sends a character by writing the display data word. Bus accesses to any other address go on to memory unchanged. The read data returned to the processor comes either from memory or from a device word.

A keystroke that arrives while the input is empty is captured, and the input then locks. Further keystrokes are dropped until software reads the captured code. The display side works the same way in the other direction. An accepted character marks the display busy, and any write made while it is busy is discarded. The display clears the busy state with a one-cycle completion pulse. Each device raises an interrupt request when its ready flag and its enable flag are both set.

Top module: `console_io_ctrl`

## Requirements
- R1: Device words sit at these exact 16-bit addresses: 0xFE00 is keyboard status, 0xFE02 is keyboard data, 0xFE04 is display status and 0xFE06 is display data.
- R2: When `kbdValid` is high and the keyboard ready flag is clear, the next clock edge stores `kbdChar`. After that edge, a read of keyboard data returns the code in bits [7:0] with bits [15:8] zero, and keyboard status bit 15 reads one.
- R3: While the keyboard ready flag is set, incoming keystrokes are dropped and the stored code stays unchanged.
- R4: A bus read of keyboard data clears the keyboard ready flag at that clock edge, and the next keystroke is then captured.
- R5: A status word reads with the ready flag in bit 15, the interrupt enable in bit 14 and zero in all other bits. A bus write to a status word changes only bit 14.
- R6: A write to display data while the display ready flag is set clears that flag. One cycle later `dispStrobe` pulses for exactly one cycle, with `dispChar` equal to bits [7:0] of the written word.
- R7: A write to display data while the display ready flag is clear is discarded: no strobe is produced and `dispChar` does not change.
- R8: A one-cycle `dispDone` pulse sets the display ready flag again. Reset sets this flag to one.
- R9: `kbdIrq` is high exactly when the keyboard ready flag and its enable are both set. `dispIrq` follows the same rule for the display.
- R10: For any other address, `busRdata` equals `memRdata`, and `memRead` and `memWrite` follow `busRead` and `busWrite`. For the four device addresses, both memory strobes stay low.
- R11: Synchronous reset clears the keyboard ready flag, both enables and `dispStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 16 | Bus word address |
| busRead | input | 1 | Bus read strobe |
| busWrite | input | 1 | Bus write strobe |
| busWdata | input | 16 | Bus write data |
| busRdata | output | 16 | Read data returned to the processor |
| memRdata | input | 16 | Read data from memory |
| memRead | output | 1 | Read strobe passed to memory |
| memWrite | output | 1 | Write strobe passed to memory |
| kbdChar | input | 8 | Keystroke code |
| kbdValid | input | 1 | Keystroke present this cycle |
| dispChar | output | 8 | Character presented to the display |
| dispStrobe | output | 1 | One-cycle pulse: new display character |
| dispDone | input | 1 | One-cycle pulse: display finished |
| kbdIrq | output | 1 | Keyboard interrupt request |
| dispIrq | output | 1 | Display interrupt request |

## Verification
The bench presses a second key before the first has been read. A design without the input lock would return the newer code. It also writes the display while the display is busy; a leaky design would produce a second strobe or change `dispChar`. Status writes use all ones, so a design that let software set a ready flag would read back bit 15 set or raise an interrupt. Addresses one off from the device words, such as 0xFE01, 0xFE08 and 0x7E06, must reach memory, which catches a decoder that compares only part of the address.

// File: rtl/console_io_pkg.sv
package console_io_pkg;

  typedef enum logic [2:0] {
    SEL_MEM,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } rdSel_t;

  typedef struct packed {
    logic   kbdStatWr;
    logic   kbdDataRd;
    logic   dispStatWr;
    logic   dispDataWr;
    rdSel_t rdSel;
  } ioCtl_t;

endpackage

// File: rtl/console_io_decode.sv
module console_io_decode
  import console_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KBD_STAT_ADDR  = 16'hFE00,
  parameter logic [ADDR_W-1:0] KBD_DATA_ADDR  = 16'hFE02,
  parameter logic [ADDR_W-1:0] DISP_STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DISP_DATA_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output ioCtl_t            ctl,
  output logic              memRead,
  output logic              memWrite
);
  localparam int N_REGS = 4;
  localparam logic [N_REGS*ADDR_W-1:0] ADDR_TABLE =
    {DISP_DATA_ADDR, DISP_STAT_ADDR, KBD_DATA_ADDR, KBD_STAT_ADDR};

  logic [N_REGS-1:0] hit;
  logic              devHit;

  for (genvar i = 0; i < N_REGS; i++) begin : gHit
    assign hit[i] = (busAddr == ADDR_TABLE[i*ADDR_W +: ADDR_W]);
  end

  assign devHit = |hit;

  always_comb begin
    ctl            = '0;
    ctl.rdSel      = SEL_MEM;
    ctl.kbdStatWr  = busWrite && hit[0];
    ctl.kbdDataRd  = busRead  && hit[1];
    ctl.dispStatWr = busWrite && hit[2];
    ctl.dispDataWr = busWrite && hit[3];
    if (hit[0])      ctl.rdSel = SEL_KSTAT;
    else if (hit[1]) ctl.rdSel = SEL_KDATA;
    else if (hit[2]) ctl.rdSel = SEL_DSTAT;
    else if (hit[3]) ctl.rdSel = SEL_DDATA;
  end

  assign memRead  = busRead  && !devHit;
  assign memWrite = busWrite && !devHit;

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.kbdStatWr, ctl.kbdDataRd, ctl.dispStatWr, ctl.dispDataWr}));

  assert_mem_block_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl.rdSel != SEL_MEM) |-> (!memRead && !memWrite));

endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
  import console_io_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ioCtl_t            ctl,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CHAR_W-1:0] kbdChar,
  input  logic              kbdValid,
  output logic [CHAR_W-1:0] dispChar,
  output logic              dispStrobe,
  input  logic              dispDone,
  output logic              kbdIrq,
  output logic              dispIrq
);
  localparam int READY_BIT = DATA_W - 1;
  localparam int IE_BIT    = DATA_W - 2;
  localparam int PAD_W     = DATA_W - CHAR_W;

  logic              kbdReady, kbdIe, dispReady, dispIe;
  logic [CHAR_W-1:0] kbdData, dispCharQ;
  logic              dispAccept;

  assign dispAccept = ctl.dispDataWr && dispReady;

  // keyboard side
  always_ff @(posedge clk) begin
    if (rst) begin
      kbdReady <= 1'b0;
      kbdIe    <= 1'b0;
      kbdData  <= '0;
    end else begin
      if (!kbdReady && kbdValid) begin
        kbdReady <= 1'b1;
        kbdData  <= kbdChar;
      end else if (kbdReady && ctl.kbdDataRd) begin
        kbdReady <= 1'b0;
      end
      if (ctl.kbdStatWr) kbdIe <= busWdata[IE_BIT];
    end
  end

  // display side
  always_ff @(posedge clk) begin
    if (rst) begin
      dispReady  <= 1'b1;
      dispIe     <= 1'b0;
      dispCharQ  <= '0;
      dispStrobe <= 1'b0;
    end else begin
      dispStrobe <= dispAccept;
      if (dispAccept) begin
        dispReady <= 1'b0;
        dispCharQ <= busWdata[CHAR_W-1:0];
      end else if (dispDone) begin
        dispReady <= 1'b1;
      end
      if (ctl.dispStatWr) dispIe <= busWdata[IE_BIT];
    end
  end

  function automatic logic [DATA_W-1:0] statusWord(input logic rdy, input logic ie);
    logic [DATA_W-1:0] w;
    w            = '0;
    w[READY_BIT] = rdy;
    w[IE_BIT]    = ie;
    return w;
  endfunction

  always_comb begin
    unique case (ctl.rdSel)
      SEL_KSTAT: busRdata = statusWord(kbdReady, kbdIe);
      SEL_KDATA: busRdata = {{PAD_W{1'b0}}, kbdData};
      SEL_DSTAT: busRdata = statusWord(dispReady, dispIe);
      SEL_DDATA: busRdata = {{PAD_W{1'b0}}, dispCharQ};
      default:   busRdata = memRdata;
    endcase
  end

  assign dispChar = dispCharQ;
  assign kbdIrq   = kbdReady && kbdIe;
  assign dispIrq  = dispReady && dispIe;

  assert_kbd_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!kbdReady && kbdValid) |=> (kbdReady && kbdData == $past(kbdChar)));

  assert_kbd_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (kbdReady && !ctl.kbdDataRd) |=> (kbdReady && $stable(kbdData)));

  assert_kbd_release_R4: assert property (@(posedge clk) disable iff (rst)
    (kbdReady && ctl.kbdDataRd) |=> !kbdReady);

  assert_disp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    dispStrobe |=> !dispStrobe);

  assert_disp_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (!dispReady && ctl.dispDataWr) |=> (!dispStrobe && $stable(dispCharQ)));

  assert_disp_done_R8: assert property (@(posedge clk) disable iff (rst)
    (dispDone && !dispAccept) |=> dispReady);

endmodule

// File: rtl/console_io_ctrl.sv
module console_io_ctrl
  import console_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRead,
  output logic              memWrite,
  input  logic [CHAR_W-1:0] kbdChar,
  input  logic              kbdValid,
  output logic [CHAR_W-1:0] dispChar,
  output logic              dispStrobe,
  input  logic              dispDone,
  output logic              kbdIrq,
  output logic              dispIrq
);
  ioCtl_t ctl;

  console_io_decode #(.ADDR_W(ADDR_W)) uDecode (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .ctl(ctl), .memRead(memRead), .memWrite(memWrite)
  );

  console_io_regs #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) uRegs (
    .clk(clk), .rst(rst), .ctl(ctl), .busWdata(busWdata),
    .memRdata(memRdata), .busRdata(busRdata), .kbdChar(kbdChar),
    .kbdValid(kbdValid), .dispChar(dispChar), .dispStrobe(dispStrobe),
    .dispDone(dispDone), .kbdIrq(kbdIrq), .dispIrq(dispIrq)
  );

endmodule

// File: tb/console_io_ctrl_test.sv
module console_io_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] busAddr, busWdata, busRdata, memRdata;
  logic        busRead, busWrite, memRead, memWrite;
  logic [7:0]  kbdChar, dispChar;
  logic        kbdValid, dispStrobe, dispDone, kbdIrq, dispIrq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  assign memRdata = busAddr ^ 16'hA5C3;

  console_io_ctrl uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .memRdata(memRdata), .memRead(memRead), .memWrite(memWrite),
    .kbdChar(kbdChar), .kbdValid(kbdValid), .dispChar(dispChar),
    .dispStrobe(dispStrobe), .dispDone(dispDone), .kbdIrq(kbdIrq),
    .dispIrq(dispIrq)
  );

  // {address, isDevice}
  localparam logic [16:0] VECS [0:8] = '{
    {16'hFE00, 1'b1}, {16'hFE02, 1'b1}, {16'hFE04, 1'b1}, {16'hFE06, 1'b1},
    {16'hFE01, 1'b0}, {16'hFE08, 1'b0}, {16'h0000, 1'b0}, {16'hFFFF, 1'b0},
    {16'h7E06, 1'b0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    busRead = 0; busWrite = 0; busAddr = 16'h0100; busWdata = 0;
    kbdValid = 0; kbdChar = 0; dispDone = 0;
  endtask

  task automatic busRd(input logic [15:0] a, output logic [15:0] d);
    busAddr = a; busRead = 1;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic busWr(input logic [15:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWrite = 1;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic press(input logic [7:0] c);
    kbdChar = c; kbdValid = 1;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    idle();
    rst = 1;
    tick(); tick();
    rst = 0;

    // reset state (R11, R8)
    busRd(16'hFE00, d); check("R11 kbd status after reset", d, 16'h0000);
    busRd(16'hFE04, d); check("R8 disp status after reset", d, 16'h8000);
    check("R11 strobe/irqs after reset", {13'b0, dispStrobe, kbdIrq, dispIrq}, 16'h0000);

    // address vectors (R1, R10)
    for (int i = 0; i < 9; i++) begin
      busAddr = VECS[i][16:1]; busRead = 1;
      #1;
      check("R10 memRead", {15'b0, memRead}, {15'b0, !VECS[i][0]});
      if (!VECS[i][0]) check("R10 pass-through data", busRdata, VECS[i][16:1] ^ 16'hA5C3);
      else check("R1 device data not memory", {15'b0, busRdata == memRdata}, 16'h0000);
      busRead = 0; busWrite = 1;
      #1 check("R10 memWrite", {15'b0, memWrite}, {15'b0, !VECS[i][0]});
      idle();
      tick();
    end

    // keyboard capture, lock and release (R2, R3, R4)
    press(8'h41);
    busRd(16'hFE00, d); check("R2 ready set", d, 16'h8000);
    press(8'h42);
    busRd(16'hFE02, d); check("R3 locked code kept", d, 16'h0041);
    busRd(16'hFE00, d); check("R4 ready cleared by read", d, 16'h0000);
    press(8'hDA);
    busRd(16'hFE02, d); check("R2 new code, upper zero", d, 16'h00DA);

    // status write only touches enable (R5, R9)
    busWr(16'hFE00, 16'hFFFF);
    busRd(16'hFE00, d); check("R5 only enable written", d, 16'h4000);
    check("R9 kbdIrq low when not ready", {15'b0, kbdIrq}, 16'h0000);
    press(8'h30);
    check("R9 kbdIrq high", {15'b0, kbdIrq}, 16'h0001);
    busRd(16'hFE00, d); check("R5 both bits", d, 16'hC000);
    busWr(16'hFE00, 16'h0000);
    busRd(16'hFE00, d); check("R5 ready unaffected by write", d, 16'h8000);
    check("R9 kbdIrq off after disable", {15'b0, kbdIrq}, 16'h0000);
    busRd(16'hFE02, d);

    // display write accepted (R6)
    busWr(16'hFE06, 16'h1234);
    check("R6 strobe pulse", {15'b0, dispStrobe}, 16'h0001);
    check("R6 char", {8'h00, dispChar}, 16'h0034);
    tick();
    check("R6 strobe single cycle", {15'b0, dispStrobe}, 16'h0000);
    busRd(16'hFE04, d); check("R6 ready cleared", d, 16'h0000);

    // busy write dropped (R7)
    busWr(16'hFE06, 16'h0055);
    check("R7 no strobe when busy", {15'b0, dispStrobe}, 16'h0000);
    check("R7 char unchanged", {8'h00, dispChar}, 16'h0034);

    // done pulse (R8) and display interrupt (R9)
    dispDone = 1; tick(); idle();
    busRd(16'hFE04, d); check("R8 ready after done", d, 16'h8000);
    busWr(16'hFE04, 16'hFFFF);
    check("R9 dispIrq high", {15'b0, dispIrq}, 16'h0001);
    busWr(16'hFE06, 16'h0077);
    check("R9 dispIrq low when busy", {15'b0, dispIrq}, 16'h0000);
    check("R6 second char", {8'h00, dispChar}, 16'h0077);

    // mid-run reset (R11)
    busWr(16'hFE00, 16'h4000);
    press(8'h11);
    rst = 1; tick(); rst = 0;
    busRd(16'hFE00, d); check("R11 kbd cleared by reset", d, 16'h0000);
    busRd(16'hFE04, d); check("R11 disp ready, ie cleared", d, 16'h8000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule